// File: doc/BRIEF.md
# Double-to-Single Float Narrowing Converter

This block converts a 64-bit binary floating-point word (1 sign bit, 11 exponent bits with bias 1023, 52 fraction bits) into a 32-bit word (1 sign bit, 8 exponent bits with bias 127, 23 fraction bits). It works out which class the input belongs to, normalises denormal inputs, and repacks the value into the narrow format. On the way it rounds on a fixed 7-bit guard field, clamps large values to infinity and builds subnormal results for small ones.

The unit has a single register stage. Each input word marked valid gives a result word and a 3-bit class code one cycle later, together with a one-cycle valid pulse. When no valid input arrives, the outputs keep their last values. The class code describes the input: 0 zero, 1 finite number (normal or denormal), 2 infinity, 3 quiet NaN, 4 signalling NaN.

Top module: `f64_to_f32_narrow`

## Requirements
- R1: An input with exponent field 0 and fraction 0 gets class 0. The output is the input sign followed by 31 zero bits.
- R2: An input with exponent field 0x7FF and fraction 0 gets class 2. The output is the input sign, exponent 0xFF and fraction 0.
- R3: An input with exponent field 0x7FF and a non-zero fraction is a NaN. It gets class 4 (signalling) when input bit 63 is 1, and class 3 (quiet) when bit 63 is 0.
- R4: For any NaN input, output bit 31 is forced to 1, output bits 30:23 are 0xFF, and output bits 22:0 copy input bits 22:0.
- R5: For a normal result, the 23-bit output fraction comes from input bits 51:29, and the guard field is input bits 28:22. Input bits 21:0 are ignored. A guard value above 0x40 rounds up and a guard value below 0x40 truncates. A guard value of exactly 0x40 rounds up only when input bit 29 is 1.
- R6: When rounding carries the significand to the next power of two, the output exponent goes up by one and the fraction becomes 0.
- R7: A finite input whose unbiased exponent is above 127 gives a signed infinity (0xFF exponent, fraction 0) with class 1. The same result comes from a rounding carry out of unbiased exponent 127.
- R8: A finite input whose unbiased exponent is below -126 gives output exponent 0. The fraction is the 1-prefixed significand shifted right by (-126 - exponent), with no rounding. When that shift exceeds 25, the result is a signed zero.
- R9: A denormal input (exponent field 0, fraction non-zero) is normalised and gets class 1. It therefore always gives a signed zero output.
- R10: out_valid is high in the cycle after each cycle in which in_valid is high, and low otherwise. out_word and out_class update only on valid inputs. Reset clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies in_word |
| in_word | input | 64 | Double-precision operand |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_word | output | 32 | Single-precision result |
| out_class | output | 3 | Class code of the converted input |

## Verification
The guard field is driven to 0x3F, 0x40 and 0x41, and the 0x40 case is tried with both values of the fraction LSB. A design that used round-to-nearest-even with a sticky bit would round the 0x40 case differently once the ignored low bits are set. The carry case (all-ones fraction) is run at ordinary exponents and at exponent 127. A design that missed the renormalisation would return a halved value or a finite word where infinity is required. The subnormal boundary is walked through deficits 0, 1, 23, 24 and beyond 25, which exposes off-by-one shift amounts. NaN inputs of both signs and with empty low payload bits check the forced negative sign and the class taken from the sign bit. A design that read the fraction MSB instead would swap the quiet and signalling codes.

// File: rtl/f64_to_f32_narrow.sv
module f64_to_f32_narrow (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_word,
  output logic        out_valid,
  output logic [31:0] out_word,
  output logic [2:0]  out_class
);
  localparam int DEW = 11;
  localparam int DFW = 52;
  localparam int SEW = 8;
  localparam int SFW = 23;
  localparam int GRD = 7;
  localparam int GW  = SFW + GRD + 1;
  localparam int DBIAS = 1023;
  localparam int SBIAS = 127;
  localparam int SUB_LIMIT = 25;

  localparam logic [2:0] C_ZERO = 3'd0;
  localparam logic [2:0] C_NUM  = 3'd1;
  localparam logic [2:0] C_INF  = 3'd2;
  localparam logic [2:0] C_QNAN = 3'd3;
  localparam logic [2:0] C_SNAN = 3'd4;

  logic           sgn;
  logic [DEW-1:0] dexp;
  logic [DFW-1:0] dfrac;
  assign {sgn, dexp, dfrac} = in_word;

  wire is_den  = (dexp == '0) && (dfrac != '0);
  wire is_zero = (dexp == '0) && (dfrac == '0);
  wire is_top  = (dexp == '1);

  logic [5:0] lz;
  always_comb begin
    lz = 6'd0;
    for (int i = 0; i < DFW; i++)
      if (dfrac[i]) lz = 6'(DFW - 1 - i);
  end

  logic [DFW:0]        mant;
  logic signed [12:0]  uexp;
  always_comb begin
    if (is_den) begin
      mant = {1'b0, dfrac} << (lz + 6'd1);
      uexp = -13'sd1022 - 13'(lz) - 13'sd1;
    end else begin
      mant = {1'b1, dfrac};
      uexp = $signed({2'b00, dexp}) - 13'sd1023;
    end
  end

  wire [GW-1:0] g = mant[DFW -: GW];

  wire signed [12:0] deficit = -13'sd126 - uexp;
  wire               under   = uexp < -13'sd126;
  wire               over    = uexp > 13'(SBIAS);
  wire [5:0]         sub_amt = deficit[5:0] + 6'(GRD);
  wire [GW-1:0]      sub_sh  = g >> sub_amt;
  wire [SFW-1:0]     sub_frac = (deficit > 13'sd25) ? '0 : sub_sh[SFW-1:0];

  wire [GRD-1:0] guard = g[GRD-1:0];
  wire [GW:0]    radd  = (guard == 7'h40) ? (g[GRD] ? 32'd64 : 32'd0) : 32'd63;
  wire [GW:0]    rsum  = {1'b0, g} + radd;
  wire           carry = rsum[GW];
  wire [SFW-1:0] nfrac = carry ? rsum[GW-1 -: SFW] : rsum[GW-2 -: SFW];
  wire [SEW-1:0] nexp  = 8'(uexp + 13'(SBIAS)) + {7'd0, carry};

  logic [31:0] res_c;
  logic [2:0]  cls_c;
  always_comb begin
    if (is_zero) begin
      cls_c = C_ZERO;
      res_c = {sgn, 31'd0};
    end else if (is_top && dfrac == '0) begin
      cls_c = C_INF;
      res_c = {sgn, {SEW{1'b1}}, {SFW{1'b0}}};
    end else if (is_top) begin
      cls_c = sgn ? C_SNAN : C_QNAN;
      res_c = {1'b1, {SEW{1'b1}}, dfrac[SFW-1:0]};
    end else begin
      cls_c = C_NUM;
      if (under)     res_c = {sgn, {SEW{1'b0}}, sub_frac};
      else if (over) res_c = {sgn, {SEW{1'b1}}, {SFW{1'b0}}};
      else           res_c = {sgn, nexp, nfrac};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_class <= C_ZERO;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word  <= res_c;
        out_class <= cls_c;
      end
    end
  end

  assert_valid_lat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_word) && $stable(out_class));
  assert_zero_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_word[62:0] == 63'd0 |=> out_word == {$past(in_word[63]), 31'd0} && out_class == C_ZERO);
  assert_nan_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_class == C_QNAN || out_class == C_SNAN) |-> out_word[31:23] == 9'h1FF);
  assert_inf_form_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == C_INF |-> out_word[30:0] == 31'h7F800000);
  assert_den_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_word[62:52] == 11'd0 && in_word[51:0] != 52'd0 |=> out_class == C_NUM && out_word[30:0] == 31'd0);
  assert_nan_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_word[62:52] == 11'h7FF && in_word[51:0] != 52'd0 |=> out_class == ($past(in_word[63]) ? C_SNAN : C_QNAN));
endmodule

// File: tb/sim_f64_to_f32_narrow.sv
module sim_f64_to_f32_narrow;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_word = '0;
  logic        out_valid;
  logic [31:0] out_word;
  logic [2:0]  out_class;
  string       cur_tag = "R10";

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  f64_to_f32_narrow u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
                        .out_valid(out_valid), .out_word(out_word), .out_class(out_class));

  function automatic logic [34:0] ref_conv(input logic [63:0] x);
    logic s;
    longint e, E, sh, ex;
    longint unsigned f, m, g;
    logic [2:0] c;
    logic [31:0] r;
    s = x[63];
    e = longint'(x[62:52]);
    f = longint'(x[51:0]);
    if (e == 0 && f == 0) begin
      c = 3'd0; r = {s, 31'd0};
    end else if (e == 2047 && f == 0) begin
      c = 3'd2; r = {s, 8'hFF, 23'd0};
    end else if (e == 2047) begin
      c = s ? 3'd4 : 3'd3; r = {1'b1, 8'hFF, x[22:0]};
    end else begin
      c = 3'd1;
      if (e == 0) begin
        m = f; E = -1022;
        while (m < (64'd1 << 52)) begin m = m << 1; E = E - 1; end
      end else begin
        m = f | (64'd1 << 52); E = e - 1023;
      end
      g = m >> 22;
      if (E < -126) begin
        sh = -126 - E;
        r = {s, 31'd0};
        if (sh <= 25) r[22:0] = 23'(g >> (sh + 7));
      end else if (E > 127) begin
        r = {s, 8'hFF, 23'd0};
      end else begin
        ex = E + 127;
        if ((g & 127) == 64) begin
          if (((g >> 7) & 1) == 1) g = g + 64;
        end else g = g + 63;
        if (g >= 64'h80000000) begin g = g >> 1; ex = ex + 1; end
        r = {s, 8'(ex), 23'(g >> 7)};
      end
    end
    return {c, r};
  endfunction

  function automatic logic [63:0] mk(input logic s, input int e, input longint unsigned f);
    return {s, 11'(e), 52'(f)};
  endfunction

  logic        exp_v = 1'b0;
  logic [31:0] exp_w = '0;
  logic [2:0]  exp_c = '0;

  always @(posedge clk) begin
    string t;
    logic [34:0] rv;
    t = cur_tag;
    if (!rst_n) begin
      exp_v = 1'b0; exp_w = '0; exp_c = '0; t = "R10";
    end else begin
      exp_v = in_valid;
      if (in_valid) begin
        rv = ref_conv(in_word);
        exp_c = rv[34:32]; exp_w = rv[31:0];
      end else t = "R10";
    end
    #2;
    if (!done) begin
      n_tests++;
      if (out_valid !== exp_v || out_word !== exp_w || out_class !== exp_c) begin
        n_fail++;
        $display("FAIL %s: valid=%0b word=%h class=%0d expected valid=%0b word=%h class=%0d",
                 t, out_valid, out_word, out_class, exp_v, exp_w, exp_c);
      end
    end
  end

  task automatic send(input logic [63:0] x, input string t);
    @(negedge clk);
    in_valid = 1'b1; in_word = x; cur_tag = t;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_word = 64'hDEAD_BEEF_0BAD_F00D; cur_tag = "R10";
    end
  endtask

  function automatic longint unsigned gf(input int guard, input bit lsb, input longint unsigned low);
    return (longint'(guard) << 22) | (longint'(lsb) << 29) | low;
  endfunction

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R1 signed zeros
    send(mk(0, 0, 0), "R1");
    send(mk(1, 0, 0), "R1");
    // R2 infinities
    send(mk(0, 2047, 0), "R2");
    send(mk(1, 2047, 0), "R2");
    // R3 / R4 NaNs
    send(mk(0, 2047, 64'h8000000000123), "R3");
    send(mk(1, 2047, 64'h0000000400001), "R3");
    send(mk(0, 2047, 64'h8000000000000), "R4");
    send(mk(0, 2047, 64'h00000007FFFFF), "R4");
    idle(2);
    // R5 plain values and guard field
    send(mk(0, 1023, 0), "R5");
    send(mk(1, 1024, 64'h4000000000000), "R5");
    send(mk(0, 1023, gf(7'h40, 0, 0)), "R5");
    send(mk(0, 1023, gf(7'h40, 1, 0)), "R5");
    send(mk(0, 1023, gf(7'h3F, 0, 64'h3FFFFF)), "R5");
    send(mk(0, 1023, gf(7'h41, 0, 0)), "R5");
    send(mk(0, 1023, gf(7'h40, 0, 64'h3FFFFF)), "R5");
    send(mk(1, 1000, gf(7'h7F, 1, 0)), "R5");
    // R6 carry
    send(mk(0, 1023, 64'hFFFFFFFFFFFFF), "R6");
    send(mk(1, 900, 64'hFFFFFFFC00000), "R6");
    // R7 overflow
    send(mk(0, 1151, 0), "R7");
    send(mk(1, 2046, 64'h123), "R7");
    send(mk(0, 1150, 64'hFFFFFFFFFFFFF), "R7");
    send(mk(0, 1150, 0), "R7");
    // R8 subnormal outputs
    send(mk(0, 897, 0), "R8");
    send(mk(0, 896, 64'h8000000000000), "R8");
    send(mk(1, 874, 0), "R8");
    send(mk(0, 873, 64'hFFFFFFFFFFFFF), "R8");
    send(mk(0, 872, 64'hFFFFFFFFFFFFF), "R8");
    send(mk(1, 800, 0), "R8");
    // R9 denormal inputs
    send(mk(0, 0, 1), "R9");
    send(mk(1, 0, 64'hFFFFFFFFFFFFF), "R9");
    idle(3);
    for (int i = 0; i < 400; i++) begin
      int e;
      e = (i % 2 == 0) ? int'(($urandom % 300) + 860) : int'($urandom % 2048);
      send(mk(1'($urandom), e, {32'($urandom), 32'($urandom)} & 64'hFFFFFFFFFFFFF), "R5");
      if (i % 7 == 0) idle(1);
    end
    idle(3);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule